// File: doc/BRIEF.md
# Indexed Register Slave on a Two-Wire Serial Bus

This block is a two-wire serial bus target that holds a small bank of 8-bit control registers. It runs from a fast local clock and oversamples the bus. SCL and SDA pass through two-stage synchronizers, and the block finds start, stop and clock edges from the synchronized levels. SDA is driven as an open-drain line. The block only ever pulls it low through `sda_oe`.

Every transfer is framed by an index and a count.

- **Write:** the host addresses the device for writing. It sends a starting index, then a byte count, then exactly that many data bytes. These go to consecutive registers.
- **Read:** the host first sets the index with a short write-address phase. It then issues a repeated start with the read address. The device answers with the readback count byte, then the register contents from the index onward, until the host declines a byte.

Each register bit is either writable or read-only. Every bit has a power-up default. One register carries live strap input levels. A gate bit must be set before the upper registers can be reached.

Top module: `idx_reg_slave`

## Requirements
- R1: The device acknowledges the write address 0xD2 and the read address 0xD3. After any other address it gives no acknowledge and leaves SDA released for the rest of that transfer, including bytes that look like a valid frame, until the next start.
- R2: A write frame is the write address, index N, count X, then data. The index, the count and each of the first X data bytes are acknowledged, and data byte k is stored at register N+k under that register's writable-bit mask.
- R3: A data byte beyond the announced count is not acknowledged and is not stored.
- R4: After a repeated start with 0xD3, the first byte returned is the count byte, then register N, N+1 and so on. When the host does not acknowledge a byte, the device releases SDA.
- R5: After reset SDA is released and the registers read: index 2 = 0xFF, index 6 = 0x01, index 8 = 0x07, every other register 0x00 (index 0 apart from its strap bits).
- R6: Register 0 bits [4:0] are read-only and always show the current `strap_i` level. Bits [7:5] are writable.
- R7: Register 6 is a read-only identifier fixed at 0x01 (upper nibble revision 0, lower nibble vendor 1). Writes to it have no effect.
- R8: Register 8 bits [2:0] hold the readback count and are writable. Bits [7:3] are read-only zero. The count byte sent first in a read is {5'b0, register 8 bits [2:0]}.
- R9: Registers 11 to 14 are reachable only while register 10 bit 7 is 1. While that bit is 0, writes to them are acknowledged but ignored, and reads return 0x00.
- R10: An index at or past the register count (15) reads 0x00, and writes to it are acknowledged and ignored.
- R11: The device changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock level from the bus |
| sda_i | input | 1 | Serial data level from the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 5 | Strap levels shown live in register 0 bits [4:0] |

## Verification
The bench builds the block with its defaults: 15 registers and 7-bit device address 0x69. That makes the gated window at indices 11 to 14 and the out-of-range index 15 both reachable with an 8-bit index. A write at index 14 therefore crosses from a gated register into empty space. The bus quarter-period is ten local clocks. This leaves the synchronizer and edge-detect delay well inside each SCL phase, so the bench sees every acknowledge and data bit settled before it samples.

// File: rtl/idx_slave_pkg.sv
`timescale 1ns/1ps
package idx_slave_pkg;
    typedef logic [7:0] byte_t;

    localparam int STRAP_W     = 5;
    localparam int STAT_IDX    = 0;
    localparam int ALLONES_IDX = 2;
    localparam int ID_IDX      = 6;
    localparam int CNT_IDX     = 8;
    localparam int GATE_IDX    = 10;
    localparam int GATE_BIT    = 7;
    localparam int EXT_LO      = 11;
    localparam int EXT_HI      = 14;

    typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TXACK} phase_e;
    typedef enum logic [1:0] {K_ADDR, K_IDX, K_CNT, K_DATA} field_e;

    typedef struct packed {
        phase_e     ph;
        field_e     fld;
        logic [2:0] bits;
        logic       got8;
        byte_t      shf;
        byte_t      idx;
        byte_t      left;
        logic       to_tx;
        logic       host_ack;
        logic       drv;
    } fsm_t;

    typedef struct packed {
        logic scl_s1, scl_s2, scl_p;
        logic sda_s1, sda_s2, sda_p;
    } sense_t;

    function automatic byte_t rw_mask(int i);
        case (i)
            STAT_IDX: return 8'hE0;
            ID_IDX:   return 8'h00;
            CNT_IDX:  return 8'h07;
            default:  return 8'hFF;
        endcase
    endfunction

    function automatic byte_t pwr_default(int i);
        case (i)
            ALLONES_IDX: return 8'hFF;
            ID_IDX:      return 8'h01;
            CNT_IDX:     return 8'h07;
            default:     return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/idx_bus_sense.sv
`timescale 1ns/1ps
module idx_bus_sense import idx_slave_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_lvl,
    output logic start_ev,
    output logic stop_ev
);
    sense_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.scl_s1 = scl_raw;
        s_d.scl_s2 = s_q.scl_s1;
        s_d.scl_p  = s_q.scl_s2;
        s_d.sda_s1 = sda_raw;
        s_d.sda_s2 = s_q.sda_s1;
        s_d.sda_p  = s_q.sda_s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_rise = s_q.scl_s2 & ~s_q.scl_p;
    assign scl_fall = ~s_q.scl_s2 & s_q.scl_p;
    assign sda_lvl  = s_q.sda_s2;
    assign start_ev = s_q.scl_s2 & s_q.scl_p & s_q.sda_p & ~s_q.sda_s2;
    assign stop_ev  = s_q.scl_s2 & s_q.scl_p & ~s_q.sda_p & s_q.sda_s2;
endmodule

// File: rtl/idx_reg_bank.sv
`timescale 1ns/1ps
module idx_reg_bank import idx_slave_pkg::*; #(
    parameter int unsigned N_REGS = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [7:0]              wr_idx,
    input  logic [7:0]              wr_data,
    output logic [N_REGS-1:0][7:0]  regs_o
);
    logic [N_REGS-1:0][7:0] regs_d, regs_q;
    logic                   ext_open;

    assign ext_open = regs_q[GATE_IDX][GATE_BIT];

    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        localparam byte_t MASK  = rw_mask(g);
        localparam bit    GATED = (g >= EXT_LO) && (g <= EXT_HI);
        logic hit;
        assign hit       = wr_en && (wr_idx == 8'(g)) && (!GATED || ext_open);
        assign regs_d[g] = hit ? ((regs_q[g] & ~MASK) | (wr_data & MASK)) : regs_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_REGS; i++) regs_q[i] <= pwr_default(i);
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs_o = regs_q;
endmodule

// File: rtl/idx_read_mux.sv
`timescale 1ns/1ps
module idx_read_mux import idx_slave_pkg::*; #(
    parameter int unsigned N_REGS = 15
) (
    input  logic [N_REGS-1:0][7:0] regs_i,
    input  logic [7:0]             rd_idx,
    input  logic [STRAP_W-1:0]     strap_i,
    output logic [7:0]             rd_data
);
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_REGS; i++) begin
            if (rd_idx == 8'(i)) rd_data = regs_i[i];
        end
        if (rd_idx == 8'(STAT_IDX)) rd_data[STRAP_W-1:0] = strap_i;
        if (rd_idx >= 8'(EXT_LO) && rd_idx <= 8'(EXT_HI) && !regs_i[GATE_IDX][GATE_BIT])
            rd_data = '0;
    end
endmodule

// File: rtl/idx_proto_fsm.sv
`timescale 1ns/1ps
module idx_proto_fsm import idx_slave_pkg::*; #(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_lvl,
    input  logic       start_ev,
    input  logic       stop_ev,
    input  logic [2:0] cnt_field,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_idx,
    output logic       wr_en,
    output logic [7:0] wr_idx,
    output logic [7:0] wr_data,
    output logic       sda_oe
);
    localparam byte_t WR_BYTE = {DEV_ADDR, 1'b0};
    localparam byte_t RD_BYTE = {DEV_ADDR, 1'b1};

    fsm_t f_d, f_q;

    always_comb begin
        f_d     = f_q;
        wr_en   = 1'b0;
        wr_idx  = f_q.idx;
        wr_data = f_q.shf;
        if (stop_ev) begin
            f_d.ph  = ST_IDLE;
            f_d.drv = 1'b0;
        end else if (start_ev) begin
            f_d.ph   = ST_RX;
            f_d.fld  = K_ADDR;
            f_d.bits = '0;
            f_d.got8 = 1'b0;
            f_d.drv  = 1'b0;
        end else begin
            case (f_q.ph)
                ST_RX: begin
                    if (scl_rise && !f_q.got8) begin
                        f_d.shf  = {f_q.shf[6:0], sda_lvl};
                        f_d.bits = f_q.bits + 3'd1;
                        if (f_q.bits == 3'd7) f_d.got8 = 1'b1;
                    end else if (scl_fall && f_q.got8) begin
                        f_d.got8  = 1'b0;
                        f_d.bits  = '0;
                        f_d.to_tx = 1'b0;
                        f_d.ph    = ST_ACK;
                        f_d.drv   = 1'b1;
                        case (f_q.fld)
                            K_ADDR: begin
                                if (f_q.shf == WR_BYTE) begin
                                    f_d.fld = K_IDX;
                                end else if (f_q.shf == RD_BYTE) begin
                                    f_d.to_tx = 1'b1;
                                    f_d.shf   = {5'b0, cnt_field};
                                end else begin
                                    f_d.ph  = ST_IDLE;
                                    f_d.drv = 1'b0;
                                end
                            end
                            K_IDX: begin
                                f_d.idx = f_q.shf;
                                f_d.fld = K_CNT;
                            end
                            K_CNT: begin
                                f_d.left = f_q.shf;
                                f_d.fld  = K_DATA;
                            end
                            default: begin
                                if (f_q.left != 8'd0) begin
                                    wr_en    = 1'b1;
                                    f_d.idx  = f_q.idx + 8'd1;
                                    f_d.left = f_q.left - 8'd1;
                                end else begin
                                    f_d.ph  = ST_IDLE;
                                    f_d.drv = 1'b0;
                                end
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        f_d.bits = '0;
                        if (f_q.to_tx) begin
                            f_d.ph  = ST_TX;
                            f_d.drv = ~f_q.shf[7];
                        end else begin
                            f_d.ph   = ST_RX;
                            f_d.got8 = 1'b0;
                            f_d.drv  = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (f_q.bits == 3'd7) begin
                            f_d.ph       = ST_TXACK;
                            f_d.drv      = 1'b0;
                            f_d.host_ack = 1'b0;
                        end else begin
                            f_d.shf  = {f_q.shf[6:0], 1'b0};
                            f_d.bits = f_q.bits + 3'd1;
                            f_d.drv  = ~f_q.shf[6];
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise) begin
                        f_d.host_ack = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (f_q.host_ack) begin
                            f_d.shf  = rd_data;
                            f_d.idx  = f_q.idx + 8'd1;
                            f_d.ph   = ST_TX;
                            f_d.bits = '0;
                            f_d.drv  = ~rd_data[7];
                        end else begin
                            f_d.ph = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q     <= '0;
            f_q.ph  <= ST_IDLE;
            f_q.fld <= K_ADDR;
        end else begin
            f_q <= f_d;
        end
    end

    assign rd_idx = f_q.idx;
    assign sda_oe = f_q.drv;
endmodule

// File: rtl/idx_reg_slave.sv
`timescale 1ns/1ps
module idx_reg_slave import idx_slave_pkg::*; #(
    parameter int unsigned N_REGS   = 15,
    parameter logic [6:0]  DEV_ADDR = 7'h69
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] strap_i
);
    logic                   scl_rise, scl_fall, sda_lvl, start_ev, stop_ev;
    logic                   wr_en;
    logic [7:0]             wr_idx, wr_data, rd_idx, rd_data;
    logic [N_REGS-1:0][7:0] reg_view;

    idx_bus_sense u_sense (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    idx_proto_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_lvl(sda_lvl), .start_ev(start_ev), .stop_ev(stop_ev),
        .cnt_field(reg_view[CNT_IDX][2:0]), .rd_data(rd_data), .rd_idx(rd_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_oe(sda_oe)
    );

    idx_reg_bank #(.N_REGS(N_REGS)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .regs_o(reg_view)
    );

    idx_read_mux #(.N_REGS(N_REGS)) u_rmux (
        .regs_i(reg_view), .rd_idx(rd_idx), .strap_i(strap_i), .rd_data(rd_data)
    );
endmodule

// File: rtl/idx_reg_slave_chk.sv
`timescale 1ns/1ps
module idx_reg_slave_chk import idx_slave_pkg::*; #(
    parameter int unsigned N_REGS = 15
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   scl_i,
    input logic                   sda_oe,
    input logic [STRAP_W-1:0]     strap_i,
    input logic [7:0]             rd_idx,
    input logic [7:0]             rd_data,
    input logic                   wr_en,
    input logic [7:0]             wr_idx,
    input logic [7:0]             wr_data,
    input logic [N_REGS-1:0][7:0] reg_view
);
    a_r11_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    a_r6_strap_live: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == 8'(STAT_IDX)) |-> (rd_data[STRAP_W-1:0] == strap_i));

    a_r10_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx >= 8'(N_REGS)) |-> (rd_data == 8'h00));

    a_r9_gated_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_view[GATE_IDX][GATE_BIT] |=> $stable(reg_view[EXT_HI:EXT_LO]));

    a_r7_id_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        reg_view[ID_IDX] == 8'h01);

    a_r8_count_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_view[CNT_IDX][7:3] == 5'd0);

    a_r2_store_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 8'(ALLONES_IDX)) |=> (reg_view[ALLONES_IDX] == $past(wr_data)));
endmodule

bind idx_reg_slave idx_reg_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .strap_i(strap_i),
    .rd_idx(rd_idx), .rd_data(rd_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .reg_view(reg_view)
);

// File: tb/idx_reg_slave_test.sv
`timescale 1ns/1ps
module idx_reg_slave_test;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [4:0] strap = 5'b10110;
    logic       sda_oe;
    wire        sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    idx_reg_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap_i(strap)
    );

    int         n_chk = 0;
    int         n_err = 0;
    int         r11_bad = 0;
    logic       oe_prev = 1'b0;
    logic [7:0] wbuf [16];
    logic [7:0] rbuf [16];
    logic       ack_v [16];
    logic [7:0] cnt_byte;
    logic       addr_ack, idx_ack, cnt_ack, raddr_ack, oe_after;

    always @(negedge clk) begin
        if (rst_n && sda_oe !== oe_prev && scl_m) r11_bad++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic qw(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qw(); scl_m = 1'b1; qw(2); scl_m = 1'b0; qw();
        end
        sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); ack = ~sda_line; qw(); scl_m = 1'b0; qw();
    endtask

    task automatic get_byte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qw(); scl_m = 1'b1; qw(); b[i] = sda_line; qw(); scl_m = 1'b0;
        end
        qw(); sda_m = nack; qw(); scl_m = 1'b1; qw(2); scl_m = 1'b0; qw(); sda_m = 1'b1;
    endtask

    task automatic blk_write(input logic [7:0] idx, input logic [7:0] cnt, input int nb);
        logic a;
        bus_start();
        put_byte(8'hD2, a); addr_ack = a;
        put_byte(idx, a);   idx_ack = a;
        put_byte(cnt, a);   cnt_ack = a;
        for (int i = 0; i < nb; i++) begin
            put_byte(wbuf[i], a); ack_v[i] = a;
        end
        bus_stop();
    endtask

    task automatic blk_read(input logic [7:0] idx, input int nb);
        logic a;
        logic [7:0] v;
        bus_start();
        put_byte(8'hD2, a); addr_ack = a;
        put_byte(idx, a);   idx_ack = a;
        bus_rstart();
        put_byte(8'hD3, a); raddr_ack = a;
        get_byte(1'b0, v); cnt_byte = v;
        for (int i = 0; i < nb; i++) begin
            get_byte(i == nb - 1, v); rbuf[i] = v;
        end
        qw();
        oe_after = sda_oe;
        bus_stop();
    endtask

    task automatic t_reset();
        logic [7:0] exp [7];
        exp = '{8'h16, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h01};
        chk("R5 sda released after reset", {7'd0, sda_oe}, 8'h00);
        blk_read(8'd0, 7);
        chk("R1 write address acked", {7'd0, addr_ack}, 8'h01);
        chk("R1 read address acked", {7'd0, raddr_ack}, 8'h01);
        chk("R8 default count byte", cnt_byte, 8'h07);
        chk("R6 strap bits in reg0", rbuf[0], exp[0]);
        for (int i = 1; i < 6; i++) chk("R5 default value", rbuf[i], exp[i]);
        chk("R7 identifier", rbuf[6], exp[6]);
        chk("R4 release after host nack", {7'd0, oe_after}, 8'h00);
    endtask

    task automatic t_write_read();
        wbuf[0] = 8'hA5; wbuf[1] = 8'h5A; wbuf[2] = 8'h3C;
        blk_write(8'd3, 8'd3, 3);
        chk("R2 index acked", {7'd0, idx_ack}, 8'h01);
        chk("R2 count acked", {7'd0, cnt_ack}, 8'h01);
        for (int i = 0; i < 3; i++) chk("R2 data acked", {7'd0, ack_v[i]}, 8'h01);
        blk_read(8'd3, 4);
        chk("R4 count byte first", cnt_byte, 8'h07);
        chk("R2 reg3", rbuf[0], 8'hA5);
        chk("R2 reg4", rbuf[1], 8'h5A);
        chk("R2 reg5", rbuf[2], 8'h3C);
        chk("R4 increment into reg6", rbuf[3], 8'h01);
    endtask

    task automatic t_overrun();
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        blk_write(8'd4, 8'd1, 2);
        chk("R2 counted byte acked", {7'd0, ack_v[0]}, 8'h01);
        chk("R3 extra byte not acked", {7'd0, ack_v[1]}, 8'h00);
        blk_read(8'd4, 2);
        chk("R2 reg4 stored", rbuf[0], 8'h11);
        chk("R3 reg5 untouched", rbuf[1], 8'h3C);
    endtask

    task automatic t_bad_addr();
        logic a;
        bus_start();
        put_byte(8'hA4, a); chk("R1 foreign address not acked", {7'd0, a}, 8'h00);
        put_byte(8'h02, a); chk("R1 released after mismatch", {7'd0, a}, 8'h00);
        put_byte(8'h01, a);
        put_byte(8'h00, a);
        put_byte(8'hD2, a); chk("R1 own address mid-transfer ignored", {7'd0, a}, 8'h00);
        bus_stop();
        blk_read(8'd2, 1);
        chk("R1 no write from foreign transfer", rbuf[0], 8'hFF);
    endtask

    task automatic t_readonly();
        wbuf[0] = 8'hFF;
        blk_write(8'd0, 8'd1, 1);
        strap = 5'b01001;
        blk_read(8'd0, 1);
        chk("R6 writable top bits and live straps", rbuf[0], 8'hE9);
        blk_write(8'd6, 8'd1, 1);
        blk_read(8'd6, 1);
        chk("R7 identifier ignores write", rbuf[0], 8'h01);
        wbuf[0] = 8'hF2;
        blk_write(8'd8, 8'd1, 1);
        blk_read(8'd8, 1);
        chk("R8 count byte follows field", cnt_byte, 8'h02);
        chk("R8 upper bits stay zero", rbuf[0], 8'h02);
        wbuf[0] = 8'h07;
        blk_write(8'd8, 8'd1, 1);
    endtask

    task automatic t_ext_gate();
        wbuf[0] = 8'h77; wbuf[1] = 8'h88;
        blk_write(8'd11, 8'd2, 2);
        chk("R9 gated write still acked", {7'd0, ack_v[1]}, 8'h01);
        blk_read(8'd11, 2);
        chk("R9 gated reg11 reads zero", rbuf[0], 8'h00);
        chk("R9 gated reg12 reads zero", rbuf[1], 8'h00);
        wbuf[0] = 8'h80; blk_write(8'd10, 8'd1, 1);
        wbuf[0] = 8'h77; wbuf[1] = 8'h88; blk_write(8'd11, 8'd2, 2);
        blk_read(8'd10, 3);
        chk("R9 gate bit set", rbuf[0], 8'h80);
        chk("R9 open reg11", rbuf[1], 8'h77);
        chk("R9 open reg12", rbuf[2], 8'h88);
        wbuf[0] = 8'h00; blk_write(8'd10, 8'd1, 1);
        blk_read(8'd11, 1);
        chk("R9 closed gate masks read", rbuf[0], 8'h00);
        wbuf[0] = 8'h99; blk_write(8'd11, 8'd1, 1);
        wbuf[0] = 8'h80; blk_write(8'd10, 8'd1, 1);
        blk_read(8'd11, 1);
        chk("R9 closed gate ignored write", rbuf[0], 8'h77);
    endtask

    task automatic t_range();
        wbuf[0] = 8'hC3; wbuf[1] = 8'h3C;
        blk_write(8'd14, 8'd2, 2);
        chk("R10 write past end acked", {7'd0, ack_v[1]}, 8'h01);
        blk_read(8'd14, 2);
        chk("R9 last gated reg stored", rbuf[0], 8'hC3);
        chk("R10 index 15 reads zero", rbuf[1], 8'h00);
        wbuf[0] = 8'h55;
        blk_write(8'h20, 8'd1, 1);
        blk_read(8'h20, 1);
        chk("R10 far index reads zero", rbuf[0], 8'h00);
    endtask

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        qw(2);
        t_reset();
        t_write_read();
        t_overrun();
        t_bad_addr();
        t_readonly();
        t_ext_gate();
        t_range();
        chk("R11 drive changes only with SCL low", 8'(r11_bad), 8'h00);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (180000) @(negedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule